// File: doc/BRIEF.md
# Four-Pin General Purpose I/O Controller

This block gives software control of four general purpose pins through a small register port. Each pin has an output-enable bit and an output-data bit. Neither is ever written directly. Software changes them by writing a mask to a "set" field or to a "clear" field. A 1 in the mask changes that pin's bit, and a 0 leaves it as it was. Several agents can therefore change different pins without reading first and without disturbing each other.

The pad ring gets `pin_out` and `pin_oe` for its tri-state buffers and returns the pad levels on `pin_in`. Those levels pass through a two-flop synchroniser. They can then be read from the input-data field at any time, whatever each pin's direction is.

The register port is a plain strobe interface with no back-pressure. A write completes on the clock edge where `reg_wr` is high. A read captures the addressed field on the edge where `reg_rd` is high, and `reg_rdata` holds that value from then until the next read.

Top module: `gpio_setclr`

## Requirements
- R1: While reset is asserted and directly after it, `pin_oe` and `pin_out` are all zero, and every field reads 0x00 while the pins are held low.
- R2: A write to address 2 sets each output-enable bit whose write-data bit is 1. Bits written 0 keep their value.
- R3: A write to address 3 clears each output-enable bit whose write-data bit is 1. Bits written 0 keep their value.
- R4: A write to address 0 sets, and a write to address 1 clears, the output-data bits under a 1 in the write data. This happens whatever the pin's output enable is, and `pin_out` follows from the next cycle.
- R5: Write-data bits 7 to 4 have no effect on any field, and read-data bits 7 to 4 are always zero.
- R6: Address 4 returns the pin levels in bits 3 to 0. It reflects a level held for two clock edges before the read edge. Writes to address 4 change nothing.
- R7: A read of address 0 or 1 returns the output-data register, and a read of address 2 or 3 returns the output-enable register. `reg_rdata` is loaded on the read edge. A read and a write in the same cycle return the value from before the write.
- R8: Addresses 5 to 7 read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Field address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data (mask) |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, loaded on the read edge |
| pin_in | input | 4 | Pad input levels (asynchronous) |
| pin_out | output | 4 | Output data to pads |
| pin_oe | output | 4 | Per-pin output enable, 1 drives |

## Verification
A read and a write can land on the same field in the same cycle. The bench provokes this by raising `reg_rd` and `reg_wr` together on the output-enable set address. It then judges two things. First, the captured read value must equal the scoreboard's pre-write register model. Second, `pin_oe` must show the updated value after that edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_PINS = 4;
  localparam int FIELD_W  = 8;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] A_DAT_SET = 3'd0;
  localparam logic [ADDR_W-1:0] A_DAT_CLR = 3'd1;
  localparam logic [ADDR_W-1:0] A_OE_SET  = 3'd2;
  localparam logic [ADDR_W-1:0] A_OE_CLR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PIN_IN  = 3'd4;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async[p]};
    end
    assign d_sync[p] = chain[STAGES-1];
  end
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_mask,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] q
);
  // clear dominates a simultaneous set on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_mask) & ~clr_mask;
  end

  p_zero_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask == '0 && clr_mask == '0) |=> $stable(q));

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_mask & ~clr_mask) != '0) |=>
      ((q & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)));

  p_clr_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((q & $past(clr_mask)) == '0));
endmodule

// File: rtl/gpio_regif.sv
module gpio_regif
  import gpio_pkg::*;
#(
  parameter int PINS = NUM_PINS,
  parameter int FW   = FIELD_W,
  parameter int AW   = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [FW-1:0] reg_wdata,
  input  logic          reg_rd,
  output logic [FW-1:0] reg_rdata,
  input  logic [PINS-1:0] dat_q,
  input  logic [PINS-1:0] oe_q,
  input  logic [PINS-1:0] pin_sync,
  output logic [PINS-1:0] dat_set,
  output logic [PINS-1:0] dat_clr,
  output logic [PINS-1:0] oe_set,
  output logic [PINS-1:0] oe_clr
);
  localparam int PAD = FW - PINS;

  logic [PINS-1:0] wmask;
  logic [PINS-1:0] rsel;

  assign wmask = reg_wr ? reg_wdata[PINS-1:0] : '0;

  always_comb begin
    dat_set = '0;
    dat_clr = '0;
    oe_set  = '0;
    oe_clr  = '0;
    case (reg_addr)
      A_DAT_SET: dat_set = wmask;
      A_DAT_CLR: dat_clr = wmask;
      A_OE_SET:  oe_set  = wmask;
      A_OE_CLR:  oe_clr  = wmask;
      default: ;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_DAT_SET, A_DAT_CLR: rsel = dat_q;
      A_OE_SET,  A_OE_CLR:  rsel = oe_q;
      A_PIN_IN:             rsel = pin_sync;
      default:              rsel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= {{PAD{1'b0}}, rsel};
  end

  p_upper_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[FW-1:PINS] == '0);

  p_upper_write_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[FW-1:PINS] != '0 && reg_wdata[PINS-1:0] == '0)
      |=> ($stable(dat_q) && $stable(oe_q)));

  p_unmapped_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr > A_PIN_IN) |=> reg_rdata == '0);

  p_unmapped_write_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr >= A_PIN_IN) |=> ($stable(dat_q) && $stable(oe_q)));
endmodule

// File: rtl/gpio_setclr.sv
module gpio_setclr
  import gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [FIELD_W-1:0]  reg_wdata,
  input  logic                reg_rd,
  output logic [FIELD_W-1:0]  reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] dat_set, dat_clr, oe_set, oe_clr;
  logic [NUM_PINS-1:0] dat_q, oe_q;

  gpio_pin_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(pin_sync)
  );

  gpio_regif u_regif (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .dat_q(dat_q), .oe_q(oe_q), .pin_sync(pin_sync),
    .dat_set(dat_set), .dat_clr(dat_clr), .oe_set(oe_set), .oe_clr(oe_clr)
  );

  gpio_setclr_reg #(.WIDTH(NUM_PINS)) u_dat (
    .clk(clk), .rst_n(rst_n), .set_mask(dat_set), .clr_mask(dat_clr), .q(dat_q)
  );

  gpio_setclr_reg #(.WIDTH(NUM_PINS)) u_oe (
    .clk(clk), .rst_n(rst_n), .set_mask(oe_set), .clr_mask(oe_clr), .q(oe_q)
  );

  assign pin_out = dat_q;
  assign pin_oe  = oe_q;

  p_pin_in_write_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_PIN_IN) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/sim_gpio_setclr.sv
`timescale 1ns/1ps
module sim_gpio_setclr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic [3:0] pin_in = '0;
  logic [3:0] pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;
  logic [3:0] m_oe = '0, m_dat = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  gpio_setclr u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: compares every captured read against the scoreboard queue
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      check(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pins_ok(input string tag);
    check({4'h0, pin_oe}, {4'h0, m_oe}, {tag, " pin_oe"});
    check({4'h0, pin_out}, {4'h0, m_dat}, {tag, " pin_out"});
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    pins_ok("R1 in reset");
    rst_n = 1'b1;
    idle(1);
    pins_ok("R1 after reset");
    for (int a = 0; a < 5; a++) rd(a[2:0], 8'h00, "R1 reset read");

    // output enable set
    wr(3'd2, 8'h05); m_oe = 4'h5; pins_ok("R2 oe set");
    wr(3'd2, 8'h00); pins_ok("R2 zero write");
    wr(3'd2, 8'hF2); m_oe = 4'h7; pins_ok("R5 upper ignored on set");
    rd(3'd2, 8'h07, "R7 read oe set addr");
    rd(3'd3, 8'h07, "R7 read oe clr addr");

    // output enable clear
    wr(3'd3, 8'h01); m_oe = 4'h6; pins_ok("R3 oe clear");
    wr(3'd3, 8'h00); pins_ok("R3 zero write");
    wr(3'd3, 8'hF0); pins_ok("R5 upper ignored on clear");

    // output data, including a pin whose enable is off (bit 0)
    wr(3'd0, 8'h09); m_dat = 4'h9; pins_ok("R4 data set");
    rd(3'd0, 8'h09, "R7 read data set addr");
    rd(3'd1, 8'h09, "R7 read data clr addr");
    wr(3'd1, 8'h08); m_dat = 4'h1; pins_ok("R4 data clear");
    wr(3'd1, 8'h00); pins_ok("R4 zero write");

    // pin input through the synchroniser
    pin_in = 4'hA;
    idle(2);
    rd(3'd4, 8'h0A, "R6 input level");
    wr(3'd4, 8'hFF); pins_ok("R6 write to input field");
    rd(3'd4, 8'h0A, "R6 input unchanged by write");
    pin_in = 4'h5;
    idle(2);
    rd(3'd4, 8'h05, "R6 input level 2");

    // unmapped addresses
    for (int a = 5; a < 8; a++) begin
      wr(a[2:0], 8'hFF); pins_ok("R8 unmapped write");
      rd(a[2:0], 8'h00, "R8 unmapped read");
    end

    // read and write on the same field in the same cycle
    @(negedge clk);
    reg_addr = 3'd2; reg_wdata = 8'h08; reg_wr = 1'b1; reg_rd = 1'b1;
    exp_q.push_back({4'h0, m_oe}); tag_q.push_back("R7 read with write");
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    m_oe = m_oe | 4'h8; pins_ok("R7 write with read");

    // reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    m_oe = '0; m_dat = '0;
    idle(1); pins_ok("R1 mid-run reset");
    rst_n = 1'b1;
    idle(2);
    rd(3'd2, 8'h00, "R1 oe after reset");

    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule